// File: doc/BRIEF.md
# Dual-Channel Converter Output Capture

This block sits right after the pins of a two-channel, 14-bit sampling converter. For each channel, on every conversion, it rebuilds one sample word and one out-of-range flag. The converter's data output clock drives all of the block's logic, so the rebuilt words leave in that clock domain along with a valid strobe.

Two pin arrangements are supported.

- **Full-rate mode.** Every data bit has a pin of its own, and each channel has its own overflow pin. Everything is captured on the rising clock edge.
- **Double-data-rate mode.** Each channel uses only its low seven data pins, and every pin carries a pair of bits. The even bit is taken on the rising edge and the odd bit on the falling edge that follows. Both channels' overflow flags share one pin: the channel A flag is taken on the rising edge and the channel B flag on the falling edge.

The mode pin is read only while reset is held. Whichever mode is chosen, a word and its flag leave the block with the same latency, so they stay aligned.

Top module: `adcrx_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `smp_a`=`smp_b`=0, `flag_a`=`flag_b`=0 and `valid`=0.
- R2: `ddr_mode` is sampled only on rising edges with `rst` high (0 = full rate, 1 = double data rate). A change while `rst` is low has no effect on how pins are decoded.
- R3: In full-rate mode, bit i of a channel's word equals the value of that channel's data pin i at a rising edge.
- R4: In full-rate mode, `flag_a` comes from `ovr_a` and `flag_b` from `ovr_b`, both captured at the same rising edge as the data.
- R5: In double-data-rate mode, for pin k (k = 0..6), bit 2k takes the pin value at a rising edge and bit 2k+1 takes it at the falling edge that follows. Pins 7..13 are ignored.
- R6: In double-data-rate mode, `flag_a` takes `ovr_a` at the rising edge and `flag_b` takes `ovr_a` at the following falling edge. `ovr_b` is ignored.
- R7: In both modes, a sample whose rising-edge capture happens at edge e is presented on the outputs (data and flags together) right after rising edge e+1.
- R8: After `rst` falls, `valid` stays low through the first rising edge, so a partial bit pair is never presented. It is high from the second rising edge on, once per sample period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data output clock from the converter |
| rst | input | 1 | Synchronous active-high reset |
| ddr_mode | input | 1 | Interface select, read during reset: 0 full rate, 1 double data rate |
| dat_a | input | 14 | Channel A data pins |
| dat_b | input | 14 | Channel B data pins |
| ovr_a | input | 1 | Channel A overflow pin; shared overflow pin in double-data-rate mode |
| ovr_b | input | 1 | Channel B overflow pin (full rate only) |
| smp_a | output | 14 | Rebuilt channel A sample |
| smp_b | output | 14 | Rebuilt channel B sample |
| flag_a | output | 1 | Channel A out-of-range flag, aligned with `smp_a` |
| flag_b | output | 1 | Channel B out-of-range flag, aligned with `smp_b` |
| valid | output | 1 | High when the outputs hold a completed sample |

## Verification
The bench drives all-ones, all-zeros and alternating patterns, then random words. These expose swapped even/odd bits, a pin-to-bit offset, or a falling-edge half taken from the wrong cycle, all of which scramble the rebuilt words. The shared overflow pin is driven with differing flags on its two edges while the unused pins carry noise, so a design that swaps the two halves or reads an unused pin reports the wrong channel's flag. The bench also flips the mode pin in mid-run and checks the valid strobe in the cycle just after reset; a design that decodes the mode live, or presents the partial first pair, fails these checks.

// File: rtl/adcrx_pkg.sv
package adcrx_pkg;
  typedef enum logic {MODE_FULL = 1'b0, MODE_DDR = 1'b1} cap_mode_e;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/adcrx_lane.sv
module adcrx_lane #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         ddr,
  input  logic [W-1:0] pins,
  output logic [W-1:0] word
);
  localparam int HALF = W / 2;

  logic [W-1:0]    rise_q;
  logic [HALF-1:0] fall_q;

  // rising half: all pins (full rate) or even bits (double data rate)
  always_ff @(posedge clk) rise_q <= pins;

  // falling half: odd bits carried on the low pins
  always_ff @(negedge clk) fall_q <= pins[HALF-1:0];

  for (genvar k = 0; k < HALF; k++) begin : g_pair
    always_comb begin
      if (ddr) begin
        word[2*k]   = rise_q[k];
        word[2*k+1] = fall_q[k];
      end else begin
        word[2*k]   = rise_q[2*k];
        word[2*k+1] = rise_q[2*k+1];
      end
    end
  end
endmodule

// File: rtl/adcrx_ovf_split.sv
module adcrx_ovf_split (
  input  logic clk,
  input  logic ddr,
  input  logic ovr_a,
  input  logic ovr_b,
  output logic flag_a,
  output logic flag_b
);
  logic rise_a, rise_b, fall_s;

  always_ff @(posedge clk) begin
    rise_a <= ovr_a;
    rise_b <= ovr_b;
  end

  // second half of the shared overflow pin belongs to channel B
  always_ff @(negedge clk) fall_s <= ovr_a;

  always_comb begin
    flag_a = rise_a;
    flag_b = ddr ? fall_s : rise_b;
  end
endmodule

// File: rtl/adcrx_top.sv
module adcrx_top
  import adcrx_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ddr_mode,
  input  logic [W-1:0] dat_a,
  input  logic [W-1:0] dat_b,
  input  logic         ovr_a,
  input  logic         ovr_b,
  output logic [W-1:0] smp_a,
  output logic [W-1:0] smp_b,
  output logic         flag_a,
  output logic         flag_b,
  output logic         valid
);
  cap_mode_e mode_q;
  logic      have_rise;
  logic      ddr;
  logic [NUM_CH-1:0][W-1:0] pins;
  logic [NUM_CH-1:0][W-1:0] words;
  logic      fa, fb;

  assign ddr     = (mode_q == MODE_DDR);
  assign pins[0] = dat_a;
  assign pins[1] = dat_b;

  // mode is latched only while reset is held
  always_ff @(posedge clk) begin
    if (rst) mode_q <= cap_mode_e'(ddr_mode);
  end

  // marks that a rising half has been taken since reset release
  always_ff @(posedge clk) begin
    if (rst) have_rise <= 1'b0;
    else     have_rise <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    adcrx_lane #(.W(W)) u_lane (
      .clk (clk),
      .ddr (ddr),
      .pins(pins[c]),
      .word(words[c])
    );
  end

  adcrx_ovf_split u_ovf (
    .clk   (clk),
    .ddr   (ddr),
    .ovr_a (ovr_a),
    .ovr_b (ovr_b),
    .flag_a(fa),
    .flag_b(fb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_a  <= '0;
      smp_b  <= '0;
      flag_a <= 1'b0;
      flag_b <= 1'b0;
      valid  <= 1'b0;
    end else if (have_rise) begin
      smp_a  <= words[0];
      smp_b  <= words[1];
      flag_a <= fa;
      flag_b <= fb;
      valid  <= 1'b1;
    end
  end

  // R8
  valid_first_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !valid);

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));

  // R3
  fr_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!ddr && valid) |-> (smp_a == $past(dat_a, 2) && smp_b == $past(dat_b, 2)));

  // R4
  fr_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (!ddr && valid) |-> (flag_a == $past(ovr_a, 2) && flag_b == $past(ovr_b, 2)));

  // R6
  ddr_ovf_a_chk: assert property (@(posedge clk) disable iff (rst)
    (ddr && valid) |-> flag_a == $past(ovr_a, 2));
endmodule

// File: tb/adcrx_top_test.sv
module adcrx_top_test;
  localparam int W = 14;
  localparam int H = W / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ddr_mode = 1'b0;
  logic [W-1:0] dat_a = '0, dat_b = '0;
  logic ovr_a = 1'b0, ovr_b = 1'b0;
  logic [W-1:0] smp_a, smp_b;
  logic flag_a, flag_b, valid;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] ea [0:63];
  logic [W-1:0] eb [0:63];
  logic efa [0:63];
  logic efb [0:63];

  always #5 clk = ~clk;

  adcrx_top #(.W(W)) uut (
    .clk(clk), .rst(rst), .ddr_mode(ddr_mode),
    .dat_a(dat_a), .dat_b(dat_b), .ovr_a(ovr_a), .ovr_b(ovr_b),
    .smp_a(smp_a), .smp_b(smp_b), .flag_a(flag_a), .flag_b(flag_b),
    .valid(valid)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int i);
    case (i)
      0: return 14'h3FFF;
      1: return 14'h0000;
      2: return 14'h2AAA;
      3: return 14'h1555;
      default: return W'($urandom);
    endcase
  endfunction

  // R1: reset state, then release at a falling edge +1
  task automatic do_reset(input logic mode);
    ddr_mode = mode;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(smp_a == 0 && smp_b == 0, "R1 data", smp_a | smp_b, '0);
    check(!valid && !flag_a && !flag_b, "R1 valid/flags", {valid, flag_a, flag_b}, '0);
    rst = 1'b0;
  endtask

  // compares the outputs with sample i-2 (R7 latency) and checks valid (R8)
  task automatic check_out(input int i, input string tag);
    if (i == 1) check(!valid, "R8 partial pair hidden", valid, 0);
    if (i >= 2) begin
      check(valid, "R8 valid", valid, 1);
      check(smp_a == ea[i-2], {tag, " R7 ch A"}, smp_a, ea[i-2]);
      check(smp_b == eb[i-2], {tag, " R7 ch B"}, smp_b, eb[i-2]);
      check(flag_a == efa[i-2], {tag, " flag A"}, flag_a, efa[i-2]);
      check(flag_b == efb[i-2], {tag, " flag B"}, flag_b, efb[i-2]);
    end
  endtask

  // R3 R4 (and R2 when flip is set)
  task automatic run_full(input int n, input bit flip);
    do_reset(1'b0);
    for (int i = 0; i < n + 2; i++) begin
      check_out(i, flip ? "R2 mode held" : "R3/R4 full");
      if (flip && i == 1) ddr_mode = 1'b1;
      ea[i] = pattern(i); eb[i] = ~pattern(i + 5);
      efa[i] = 1'($urandom); efb[i] = 1'($urandom);
      dat_a = ea[i]; dat_b = eb[i]; ovr_a = efa[i]; ovr_b = efb[i];
      @(posedge clk); #1;
      @(negedge clk); #1;
    end
  endtask

  // R5 R6: pin k carries bit 2k then 2k+1; ovr_a carries A then B
  task automatic run_ddr(input int n);
    logic [H-1:0] ev_a, ev_b, od_a, od_b;
    do_reset(1'b1);
    for (int i = 0; i < n + 2; i++) begin
      check_out(i, "R5/R6 ddr");
      ea[i] = pattern(i); eb[i] = pattern(i + 7);
      efa[i] = 1'($urandom); efb[i] = ~efa[i] ^ 1'(i > 8 ? $urandom : 0);
      for (int k = 0; k < H; k++) begin
        ev_a[k] = ea[i][2*k]; od_a[k] = ea[i][2*k+1];
        ev_b[k] = eb[i][2*k]; od_b[k] = eb[i][2*k+1];
      end
      dat_a = {H'($urandom), ev_a}; dat_b = {H'($urandom), ev_b};
      ovr_a = efa[i]; ovr_b = 1'($urandom);
      @(posedge clk); #1;
      dat_a = {H'($urandom), od_a}; dat_b = {H'($urandom), od_b};
      ovr_a = efb[i]; ovr_b = 1'($urandom);
      @(negedge clk); #1;
    end
  endtask

  initial begin
    run_full(20, 1'b0);
    run_ddr(30);
    run_full(12, 1'b1);
    run_ddr(8);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule